// File: doc/BRIEF.md
# Thresholded Multi-Increment Event Counter

This block is a single performance counter fed by a small event count on every clock. The count says how many times the watched event occurred in that cycle. A programmable threshold decides how that count is accumulated. With a threshold of zero the counter adds the whole per-cycle count. With a nonzero threshold n the counter adds one only in a cycle whose count exceeds n, so it counts the cycles with dense activity rather than the occurrences.

Two qualifiers gate counting. The first is a privilege mask with one bit per privilege level. The second is an instruction-set selector that admits cycles in native mode (mode bit 0), cycles in legacy mode (mode bit 1), or both. A register write port sets the threshold, the qualifier fields and a preload value. The 48-bit running value is always visible on the read port. When the counter wraps, a one-cycle overflow pulse is raised and counting continues from the wrapped value.

A two-state machine holds the accumulation mode:
- **ST_FULL** is entered on reset and on any threshold write whose stored value is zero. In this state the qualified per-cycle count is passed through whole.
- **ST_TICK** is entered on a threshold write whose stored value is nonzero. In this state at most one is passed per cycle.

Any other cycle keeps the current state.

Top module: `thresh_event_counter`

## Requirements
- R1: After reset the read value is 0, the overflow pulse is low, the threshold is 0, the privilege mask is 0 (nothing counts) and the instruction-set selector is "both".
- R2: With threshold 0 and the cycle qualified, the counter grows by the full event count of that cycle.
- R3: With threshold n in 1..5 and the cycle qualified, the counter grows by exactly 1 when the event count is greater than n, and by 0 otherwise.
- R4: A threshold write (cfg_addr 0, value in cfg_wdata[2:0]) above 5 is stored as 5.
- R5: A cycle counts only when the privilege mask bit indexed by cur_priv is set. In any other cycle the counter holds and no overflow is raised. The mask is written at cfg_addr 1, in cfg_wdata[3:0].
- R6: The instruction-set selector is written at cfg_addr 1, in cfg_wdata[5:4]. Its encodings are: 0 admits both modes, 1 admits only isa_legacy=0, 2 admits only isa_legacy=1, and 3 admits both.
- R7: A write at cfg_addr 2 loads cfg_wdata into the counter on that edge. The load takes priority over that cycle's increment and raises no overflow.
- R8: The counter wraps modulo 2^48 and keeps counting from the wrapped value. ovf_pulse is high for exactly the one cycle that follows the wrapping edge.
- R9: Threshold and qualifier writes take effect from the next cycle; the increment on the writing edge uses the old settings. A write at cfg_addr 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_count | input | 3 | Event occurrences in this cycle (0..6) |
| cur_priv | input | 2 | Current privilege level |
| isa_legacy | input | 1 | Instruction-set mode bit (1 = legacy) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 threshold, 1 qualifiers, 2 preload |
| cfg_wdata | input | 48 | Register write data |
| rd_value | output | 48 | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse after a wrap |

## Verification
The assertions check on every cycle that a preload lands exactly, that the overflow pulse never lasts two cycles, that a zero increment leaves the counter and the pulse untouched, that the stored threshold never exceeds 5, and that the tick state never passes more than one. Only the bench scenarios can show the arithmetic that ties the increment to the event count, threshold, privilege level and mode bit. They also show the clamp of an oversize threshold through its effect on counting, the one-cycle lag of configuration writes, and the wrap from a preloaded value near the top.

// File: rtl/tevc_pkg.sv
package tevc_pkg;
    typedef enum logic [1:0] {
        ISA_BOTH   = 2'd0,
        ISA_NATIVE = 2'd1,
        ISA_LEGACY = 2'd2,
        ISA_ANY    = 2'd3
    } isa_sel_e;

    typedef enum logic {
        ST_FULL = 1'b0,
        ST_TICK = 1'b1
    } inc_state_e;

    localparam logic [1:0] ADDR_THRESH  = 2'd0;
    localparam logic [1:0] ADDR_QUAL    = 2'd1;
    localparam logic [1:0] ADDR_PRELOAD = 2'd2;
endpackage

// File: rtl/tevc_qualifier.sv
module tevc_qualifier
    import tevc_pkg::*;
#(
    parameter int PRIV_LEVELS = 4,
    parameter int PRIV_W      = $clog2(PRIV_LEVELS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PRIV_LEVELS-1:0] wr_mask,
    input  logic [1:0]             wr_isa,
    input  logic [PRIV_W-1:0]      cur_priv,
    input  logic                   isa_legacy,
    output logic                   qual_ok
);
    logic [PRIV_LEVELS-1:0] mask_q;
    isa_sel_e               isa_q;
    logic [PRIV_LEVELS-1:0] lvl_hit;
    logic                   isa_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            isa_q  <= ISA_BOTH;
        end else if (wr_en) begin
            mask_q <= wr_mask;
            isa_q  <= isa_sel_e'(wr_isa);
        end
    end

    for (genvar lv = 0; lv < PRIV_LEVELS; lv++) begin : g_lvl
        assign lvl_hit[lv] = mask_q[lv] && (cur_priv == PRIV_W'(lv));
    end

    always_comb begin
        unique case (isa_q)
            ISA_NATIVE: isa_ok = !isa_legacy;
            ISA_LEGACY: isa_ok = isa_legacy;
            ISA_BOTH,
            ISA_ANY:    isa_ok = 1'b1;
            default:    isa_ok = 1'b1;
        endcase
    end

    assign qual_ok = (|lvl_hit) && isa_ok;

    AST_MASK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mask_q == $past(wr_mask)));  // R5
endmodule

// File: rtl/tevc_mode_fsm.sv
module tevc_mode_fsm
    import tevc_pkg::*;
#(
    parameter int EVT_W    = 3,
    parameter int MAX_INCR = 6,
    parameter int TH_W     = $clog2(MAX_INCR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             th_we,
    input  logic [TH_W-1:0]  th_wdata,
    input  logic [EVT_W-1:0] evt_count,
    input  logic             qual_ok,
    output logic [EVT_W-1:0] inc,
    output inc_state_e       state
);
    localparam logic [TH_W-1:0] MAX_TH = TH_W'(MAX_INCR - 1);

    logic [TH_W-1:0] thresh_q;
    logic [TH_W-1:0] th_clamped;
    inc_state_e      state_d;

    assign th_clamped = (th_wdata > MAX_TH) ? MAX_TH : th_wdata;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_FULL: if (th_we && th_clamped != '0) state_d = ST_TICK;
            ST_TICK: if (th_we && th_clamped == '0) state_d = ST_FULL;
            default: state_d = ST_FULL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FULL;
            thresh_q <= '0;
        end else begin
            state <= state_d;
            if (th_we) thresh_q <= th_clamped;
        end
    end

    always_comb begin
        inc = '0;
        if (qual_ok) begin
            unique case (state)
                ST_FULL: inc = evt_count;
                ST_TICK: inc = (EVT_W'(thresh_q) < evt_count) ? EVT_W'(1) : '0;
                default: inc = '0;
            endcase
        end
    end

    AST_THRESH_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        thresh_q <= MAX_TH);  // R4
    AST_TICK_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TICK) |-> (inc <= EVT_W'(1)));  // R3
endmodule

// File: rtl/tevc_accum.sv
module tevc_accum #(
    parameter int CNT_W = 48,
    parameter int EVT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [EVT_W-1:0] inc,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic [CNT_W:0] sum;

    assign sum = {1'b0, count} + (CNT_W+1)'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (load_en) begin
            count <= load_val;
            ovf   <= 1'b0;
        end else begin
            count <= sum[CNT_W-1:0];
            ovf   <= sum[CNT_W];
        end
    end

    AST_PRELOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count == $past(load_val)) && !ovf);  // R7
    AST_NO_DOUBLE_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);  // R8
    AST_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && inc == '0) |=> $stable(count) && !ovf);  // R5
endmodule

// File: rtl/thresh_event_counter.sv
module thresh_event_counter
    import tevc_pkg::*;
#(
    parameter int CNT_W       = 48,
    parameter int EVT_W       = 3,
    parameter int MAX_INCR    = 6,
    parameter int PRIV_LEVELS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [EVT_W-1:0]               evt_count,
    input  logic [$clog2(PRIV_LEVELS)-1:0] cur_priv,
    input  logic                           isa_legacy,
    input  logic                           cfg_we,
    input  logic [1:0]                     cfg_addr,
    input  logic [CNT_W-1:0]               cfg_wdata,
    output logic [CNT_W-1:0]               rd_value,
    output logic                           ovf_pulse
);
    localparam int TH_W   = $clog2(MAX_INCR);
    localparam int PRIV_W = $clog2(PRIV_LEVELS);

    logic             qual_ok;
    logic [EVT_W-1:0] inc;
    inc_state_e       state;
    logic             wr_th, wr_qual, wr_load;

    assign wr_th   = cfg_we && (cfg_addr == ADDR_THRESH);
    assign wr_qual = cfg_we && (cfg_addr == ADDR_QUAL);
    assign wr_load = cfg_we && (cfg_addr == ADDR_PRELOAD);

    tevc_qualifier #(.PRIV_LEVELS(PRIV_LEVELS), .PRIV_W(PRIV_W)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_qual),
        .wr_mask   (cfg_wdata[PRIV_LEVELS-1:0]),
        .wr_isa    (cfg_wdata[PRIV_LEVELS+1:PRIV_LEVELS]),
        .cur_priv  (cur_priv),
        .isa_legacy(isa_legacy),
        .qual_ok   (qual_ok)
    );

    tevc_mode_fsm #(.EVT_W(EVT_W), .MAX_INCR(MAX_INCR), .TH_W(TH_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .th_we    (wr_th),
        .th_wdata (cfg_wdata[TH_W-1:0]),
        .evt_count(evt_count),
        .qual_ok  (qual_ok),
        .inc      (inc),
        .state    (state)
    );

    tevc_accum #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (wr_load),
        .load_val(cfg_wdata),
        .inc     (inc),
        .count   (rd_value),
        .ovf     (ovf_pulse)
    );

    AST_UNQUALIFIED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_ok |-> (inc == '0));  // R5
    AST_FULL_PASSES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_ok && state == ST_FULL) |-> (inc == evt_count));  // R2
endmodule

// File: tb/thresh_event_counter_test.sv
module thresh_event_counter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt_count = '0;
    logic [1:0]  cur_priv = '0;
    logic        isa_legacy = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [47:0] cfg_wdata = '0;
    logic [47:0] rd_value;
    logic        ovf_pulse;

    int n_tests = 0;
    int n_fail  = 0;

    logic [47:0] m_cnt;
    logic        m_ovf;
    logic [2:0]  m_th;
    logic [3:0]  m_mask;
    logic [1:0]  m_isa;

    always #2 clk = ~clk;

    thresh_event_counter uut (
        .clk(clk), .rst_n(rst_n), .evt_count(evt_count), .cur_priv(cur_priv),
        .isa_legacy(isa_legacy), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_value(rd_value), .ovf_pulse(ovf_pulse)
    );

    function automatic logic [2:0] exp_inc(input logic [2:0] ev, input logic [1:0] pr,
                                           input logic lg);
        logic q;
        q = m_mask[pr] && ((m_isa == 2'd0) || (m_isa == 2'd3) ||
                           (m_isa == 2'd1 && !lg) || (m_isa == 2'd2 && lg));
        if (!q) return 3'd0;
        if (m_th == 3'd0) return ev;
        return (ev > m_th) ? 3'd1 : 3'd0;
    endfunction

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, update model at the edge, compare 1 ns later
    task automatic cyc(input logic [2:0] ev, input logic [1:0] pr, input logic lg,
                       input logic we, input logic [1:0] ad, input logic [47:0] wd,
                       input string req);
        logic [48:0] s;
        @(negedge clk);
        evt_count = ev; cur_priv = pr; isa_legacy = lg;
        cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
        @(posedge clk);
        if (we && ad == 2'd2) begin
            m_cnt = wd; m_ovf = 1'b0;
        end else begin
            s = {1'b0, m_cnt} + 49'(exp_inc(ev, pr, lg));
            m_cnt = s[47:0]; m_ovf = s[48];
        end
        if (we && ad == 2'd0) m_th = (wd[2:0] > 3'd5) ? 3'd5 : wd[2:0];
        if (we && ad == 2'd1) begin m_mask = wd[3:0]; m_isa = wd[5:4]; end
        #1;
        check(req, rd_value, m_cnt);
        check({req, " ovf"}, {47'd0, ovf_pulse}, {47'd0, m_ovf});
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_cnt = '0; m_ovf = 1'b0; m_th = '0; m_mask = '0; m_isa = '0;
        #10 rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 count", rd_value, 48'd0);
        check("R1 ovf", {47'd0, ovf_pulse}, 48'd0);
        // R1: mask 0 after reset, nothing counts
        cyc(3'd6, 2'd0, 1'b0, 1'b0, 2'd0, 48'd0, "R1 mask clear");
        // R5: enable level 2 only, both modes
        cyc(3'd4, 2'd2, 1'b0, 1'b1, 2'd1, 48'h04, "R9 old qual on write edge");
        cyc(3'd4, 2'd2, 1'b0, 1'b0, 2'd0, 48'd0, "R2 full add");
        cyc(3'd5, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R5 priv blocked");
        cyc(3'd6, 2'd2, 1'b1, 1'b0, 2'd0, 48'd0, "R2 full add legacy");
        // R6: native only
        cyc(3'd1, 2'd2, 1'b0, 1'b1, 2'd1, 48'h14, "R6 write native");
        cyc(3'd3, 2'd2, 1'b1, 1'b0, 2'd0, 48'd0, "R6 native blocks legacy");
        cyc(3'd3, 2'd2, 1'b0, 1'b0, 2'd0, 48'd0, "R6 native counts");
        // R6: legacy only
        cyc(3'd0, 2'd2, 1'b0, 1'b1, 2'd1, 48'h2F, "R6 write legacy");
        cyc(3'd2, 2'd0, 1'b0, 1'b0, 2'd0, 48'd0, "R6 legacy blocks native");
        cyc(3'd2, 2'd0, 1'b1, 1'b0, 2'd0, 48'd0, "R6 legacy counts");
        cyc(3'd2, 2'd3, 1'b0, 1'b1, 2'd1, 48'h3F, "R6 write any");
        cyc(3'd2, 2'd3, 1'b1, 1'b0, 2'd0, 48'd0, "R6 code 3 legacy");
        cyc(3'd2, 2'd3, 1'b0, 1'b0, 2'd0, 48'd0, "R6 code 3 native");
        // R3: threshold 3
        cyc(3'd6, 2'd1, 1'b0, 1'b1, 2'd0, 48'd3, "R9 threshold write uses old");
        cyc(3'd3, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R3 equal not counted");
        cyc(3'd4, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R3 above adds one");
        cyc(3'd6, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R3 max adds one");
        // R4: oversize threshold clamps to 5
        cyc(3'd0, 2'd1, 1'b0, 1'b1, 2'd0, 48'd7, "R4 write 7");
        cyc(3'd6, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R4 six over clamp");
        cyc(3'd5, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R4 five at clamp");
        // R9: address 3 ignored
        cyc(3'd0, 2'd1, 1'b0, 1'b1, 2'd3, 48'h0, "R9 addr3 write");
        cyc(3'd6, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R9 after addr3");
        // R7: preload wins over increment
        cyc(3'd6, 2'd1, 1'b0, 1'b1, 2'd2, 48'h1234_5678_9ABC, "R7 preload");
        // R8: wrap with threshold 0
        cyc(3'd0, 2'd1, 1'b0, 1'b1, 2'd0, 48'd0, "R8 th0");
        cyc(3'd0, 2'd1, 1'b0, 1'b1, 2'd2, 48'hFFFF_FFFF_FFFD, "R7 preload near top");
        cyc(3'd6, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R8 wrap");
        cyc(3'd1, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R8 after wrap");
        cyc(3'd0, 2'd1, 1'b0, 1'b1, 2'd2, 48'hFFFF_FFFF_FFFF, "R7 preload max");
        cyc(3'd1, 2'd1, 1'b0, 1'b0, 2'd0, 48'd0, "R8 wrap by one");
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [1:0] ad;
            logic [47:0] wd;
            we = ($urandom % 12) == 0;
            ad = 2'($urandom % 4);
            wd = {16'($urandom), 32'($urandom)};
            if (ad == 2'd2 && ($urandom % 2) == 0) wd = 48'hFFFF_FFFF_FFF0 | 48'(wd[3:0]);
            if (ad == 2'd0) wd = 48'($urandom % 8);
            cyc(3'($urandom % 7), 2'($urandom % 4), 1'($urandom), we, ad, wd,
                (m_th == 0) ? "R2 random" : "R3 random");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule